// File: doc/BRIEF.md
# Prescaled Seconds Counter with Alarm

This block is a free-running timer for keeping wall time. A slow reference clock reaches it as a one-cycle enable pulse in the system clock domain. A programmable prescaler groups a set number of those pulses into one increment tick. Each tick advances a 32-bit counter, so a divisor equal to the reference frequency makes the counter count seconds. Software reaches the block through a small word-addressed read/write bus. It may read the counter at any time but can never load it. The only way to change the counter is a restart command, which sets both the counter and the prescaler phase back to zero.

A 32-bit alarm compare raises an alarm flag on the tick that brings the counter to the alarm value. The all-ones alarm value means "no alarm armed". Every tick also raises an increment flag. Each flag has an enable bit placed exactly 16 positions above its status bit in the mode word. The interrupt line is high while any flag is set and its enable is set. Reading the status word returns both flags and clears them in the same access.

Top module: `rtt_timer`

## Requirements
- R1: After reset the mode word reads 0x00008000 (divisor 32768, both enables off), the alarm word reads 0xFFFFFFFF, the counter reads 0, the status word reads 0 and `irq` is low.
- R2: With divisor P in mode bits [15:0], the counter advances by exactly one after every P pulses of `slow_en`; P = 0 acts as 65536.
- R3: Writes to the counter word (offset 0x08) and to the status word (offset 0x0C) change no state.
- R4: A mode write with bit 18 set stores bits [17:0] as written and clears the counter and the prescaler phase at the same edge; bit 18 always reads back as 0.
- R5: Status bit 1 (increment flag) is set on every prescaler tick.
- R6: Status bit 0 (alarm flag) is set on the tick at which the counter becomes equal to the alarm word (offset 0x04); an alarm word of all ones never sets it.
- R7: A read of the status word returns the flags held before the access and clears them; a flag event in the same cycle as that read leaves its flag set afterwards.
- R8: `irq` is high exactly when (status bit 0 and mode bit 16) or (status bit 1 and mode bit 17).
- R9: Read data appears on `bus_rdata` in the cycle after a read access and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| slow_en | input | 1 | One-cycle pulse per period of the slow reference clock |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset; bits [3:2] select mode 0x00, alarm 0x04, counter 0x08, status 0x0C |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt request, level |

## Verification
The case that is hardest to reach from the ports is a flag event that lands in the same clock as a status read. The bench first steers the prescaler phase with a short divisor and a counted number of pulses, so that the next pulse is a rollover. It then drives that pulse in the same cycle as the status read and reads again to see that the flag survived. The zero-divisor case needs the full 65536-pulse span. The bench drives it with `slow_en` held high and checks both the value one pulse short of the tick and the value at the tick. The alarm is checked one tick before and at the matching count, and with the enables off and on.

// File: rtl/rtt_pkg.sv
package rtt_pkg;
  localparam int DATA_W      = 32;
  localparam int ADDR_W      = 4;
  localparam int NUM_EVT     = 2;
  localparam int EN_SHIFT    = 16;
  localparam int ALM_BIT     = 0;
  localparam int INC_BIT     = 1;
  localparam int RESTART_BIT = 18;

  typedef enum logic [1:0] {
    W_MODE   = 2'd0,
    W_ALARM  = 2'd1,
    W_COUNT  = 2'd2,
    W_STATUS = 2'd3
  } word_sel_e;
endpackage

// File: rtl/rtt_rst_sync.sv
module rtt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/rtt_prescaler.sv
module rtt_prescaler #(
  parameter int PRESC_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               slow_en,
  input  logic               restart,
  input  logic [PRESC_W-1:0] divisor,
  output logic               tick
);
  logic [PRESC_W-1:0] phase_q, phase_d, last;

  // zero divisor means the full 2^PRESC_W span
  always_comb begin
    if (divisor == '0) last = '1;
    else               last = divisor - PRESC_W'(1);
  end

  // >= keeps the divider bounded when the divisor shrinks mid-count
  assign tick = slow_en && !restart && (phase_q >= last);

  always_comb begin
    phase_d = phase_q;
    if (restart)      phase_d = '0;
    else if (tick)    phase_d = '0;
    else if (slow_en) phase_d = phase_q + PRESC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  p_tick_rewinds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (phase_q == '0));

  p_restart_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (phase_q == '0));
endmodule

// File: rtl/rtt_counter.sv
module rtt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             restart,
  input  logic [CNT_W-1:0] alarm_val,
  output logic [CNT_W-1:0] count,
  output logic             alarm_hit
);
  logic [CNT_W-1:0] count_q, count_d, count_inc;

  assign count_inc = count_q + CNT_W'(1);
  assign alarm_hit = tick && (count_inc == alarm_val) && (alarm_val != '1);

  always_comb begin
    count_d = count_q;
    if (restart)   count_d = '0;
    else if (tick) count_d = count_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

  assign count = count_q;

  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q != $past(count_q)) |-> ((count_q == $past(count_q) + CNT_W'(1)) || (count_q == '0)));

  p_restart_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (count_q == '0));
endmodule

// File: rtl/rtt_status.sv
module rtt_status #(
  parameter int NUM_EVT = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt,
  input  logic               clr,
  input  logic [NUM_EVT-1:0] en,
  output logic [NUM_EVT-1:0] flags,
  output logic               irq
);
  logic [NUM_EVT-1:0] flags_q, flags_d;

  // a fresh event wins over the clear of the same cycle
  assign flags_d = (flags_q & ~{NUM_EVT{clr}}) | evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign flags = flags_q;
  assign irq   = |(flags_q & en);

  p_clear_on_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && (evt == '0)) |=> (flags_q == '0));

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
    p_event_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
      evt[i] |=> flags_q[i]);
  end
endmodule

// File: rtl/rtt_timer.sv
module rtt_timer
  import rtt_pkg::*;
#(
  parameter int          PRESC_W     = 16,
  parameter int          CNT_W       = 32,
  parameter logic [15:0] PRESC_RESET = 16'h8000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_en,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic               rst_i_n;
  word_sel_e          word;
  logic               wr_mode, wr_alarm, rd_any, rd_status, restart;
  logic [PRESC_W-1:0] presc_q, presc_d;
  logic [NUM_EVT-1:0] en_q, en_d;
  logic [CNT_W-1:0]   alarm_q, alarm_d;
  logic [DATA_W-1:0]  rdata_q, rd_mux;
  logic               tick, alarm_hit;
  logic [CNT_W-1:0]   count;
  logic [NUM_EVT-1:0] evt, flags;

  rtt_rst_sync i_rst_sync (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  assign word      = word_sel_e'(bus_addr[3:2]);
  assign wr_mode   = bus_sel &&  bus_we && (word == W_MODE);
  assign wr_alarm  = bus_sel &&  bus_we && (word == W_ALARM);
  assign rd_any    = bus_sel && !bus_we;
  assign rd_status = rd_any && (word == W_STATUS);
  assign restart   = wr_mode && bus_wdata[RESTART_BIT];

  always_comb begin
    presc_d = presc_q;
    en_d    = en_q;
    alarm_d = alarm_q;
    if (wr_mode) begin
      presc_d = bus_wdata[PRESC_W-1:0];
      en_d    = bus_wdata[EN_SHIFT +: NUM_EVT];
    end
    if (wr_alarm) alarm_d = bus_wdata[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      presc_q <= PRESC_RESET[PRESC_W-1:0];
      en_q    <= '0;
      alarm_q <= '1;
    end else begin
      presc_q <= presc_d;
      en_q    <= en_d;
      alarm_q <= alarm_d;
    end
  end

  rtt_prescaler #(.PRESC_W(PRESC_W)) i_presc (
    .clk(clk), .rst_n(rst_i_n), .slow_en(slow_en), .restart(restart),
    .divisor(presc_q), .tick(tick)
  );

  rtt_counter #(.CNT_W(CNT_W)) i_count (
    .clk(clk), .rst_n(rst_i_n), .tick(tick), .restart(restart),
    .alarm_val(alarm_q), .count(count), .alarm_hit(alarm_hit)
  );

  always_comb begin
    evt          = '0;
    evt[ALM_BIT] = alarm_hit;
    evt[INC_BIT] = tick;
  end

  rtt_status #(.NUM_EVT(NUM_EVT)) i_status (
    .clk(clk), .rst_n(rst_i_n), .evt(evt), .clr(rd_status),
    .en(en_q), .flags(flags), .irq(irq)
  );

  always_comb begin
    rd_mux = '0;
    unique case (word)
      W_MODE: begin
        rd_mux[PRESC_W-1:0]           = presc_q;
        rd_mux[EN_SHIFT +: NUM_EVT]   = en_q;
      end
      W_ALARM:  rd_mux[CNT_W-1:0]   = alarm_q;
      W_COUNT:  rd_mux[CNT_W-1:0]   = count;
      W_STATUS: rd_mux[NUM_EVT-1:0] = flags;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)    rdata_q <= '0;
    else if (rd_any) rdata_q <= rd_mux;
  end

  assign bus_rdata = rdata_q;

  p_no_alarm_disarmed_r6: assert property (@(posedge clk) disable iff (!rst_i_n)
    ((alarm_q == '1) && !flags[ALM_BIT]) |=> !flags[ALM_BIT]);

  p_restart_reads_zero_r4: assert property (@(posedge clk) disable iff (!rst_i_n)
    (rd_any && (word == W_MODE)) |=> !bus_rdata[RESTART_BIT]);

  p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_i_n)
    !rd_any |=> $stable(bus_rdata));
endmodule

// File: tb/test_rtt_timer.sv
module test_rtt_timer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_en = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_checks = 0;
  int n_fail   = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rtt_timer i_rtt_timer (
    .clk(clk), .rst_n(rst_n), .slow_en(slow_en), .bus_sel(bus_sel),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check_val(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // monitor: pops the expected item for each read the design serves
  always @(posedge clk) begin
    if (bus_sel && !bus_we) begin
      #(CLK_PERIOD/4);
      if (exp_q.size() == 0) check_val("scoreboard underflow", bus_rdata, 32'hDEAD_BEEF);
      else check_val(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic read_with_pulse(input logic [3:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a; slow_en = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    bus_sel = 1'b0; slow_en = 1'b0;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      slow_en = 1'b1;
    end
    @(negedge clk);
    slow_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check_val("R1 irq after reset", {31'd0, irq}, 32'd0);
    bus_read(4'h0, 32'h0000_8000, "R1 mode reset");
    bus_read(4'h4, 32'hFFFF_FFFF, "R1 alarm reset");
    bus_read(4'h8, 32'h0000_0000, "R1 counter reset");
    bus_read(4'hC, 32'h0000_0000, "R1 status reset");

    // R4 restart with divisor 4; bit 18 reads 0
    bus_write(4'h0, 32'h0004_0004);
    bus_read(4'h0, 32'h0000_0004, "R4 restart bit reads zero");
    bus_read(4'hC, 32'h0, "R7 status cleared");

    // R2 / R5 divisor 4
    pulses(8);
    bus_read(4'h8, 32'd2, "R2 8 pulses at P=4");
    bus_read(4'hC, 32'h2, "R5 increment flag");
    bus_read(4'hC, 32'h0, "R7 second status read is zero");

    // R3 writes to counter and status ignored
    bus_write(4'h8, 32'h0000_1234);
    bus_read(4'h8, 32'd2, "R3 counter write ignored");
    pulses(1);
    bus_write(4'hC, 32'h0000_0003);
    bus_read(4'hC, 32'h0, "R3 status write ignored");

    // R2 partial phase
    pulses(2);
    bus_read(4'h8, 32'd2, "R2 no tick before P pulses");
    pulses(1);
    bus_read(4'h8, 32'd3, "R2 tick on P-th pulse");

    // R9 read data holds across idle cycles
    held = bus_rdata;
    pulses(4);
    check_val("R9 rdata holds", bus_rdata, held);

    // R4 restart mid-phase
    pulses(2);
    bus_write(4'h0, 32'h0004_0004);
    pulses(3);
    bus_read(4'h8, 32'd0, "R4 restart cleared count and phase");
    pulses(1);
    bus_read(4'h8, 32'd1, "R4 first tick after restart");

    // R2 zero divisor means 65536
    bus_write(4'h0, 32'h0004_0000);
    pulses(65535);
    bus_read(4'h8, 32'd0, "R2 P=0 one pulse short");
    pulses(1);
    bus_read(4'h8, 32'd1, "R2 P=0 tick at 65536");

    // R6 / R8 alarm
    bus_write(4'h0, 32'h0004_0002);
    bus_write(4'h4, 32'd3);
    bus_read(4'h4, 32'd3, "R6 alarm readback");
    bus_read(4'hC, 32'h2, "R7 leftover increment flag");
    pulses(4);
    bus_read(4'hC, 32'h2, "R6 no alarm before match");
    pulses(2);
    check_val("R8 irq low with enables off", {31'd0, irq}, 32'd0);
    bus_write(4'h0, 32'h0001_0002);
    check_val("R8 irq high with alarm enable", {31'd0, irq}, 32'd1);
    bus_read(4'hC, 32'h3, "R6 alarm flag at match");
    check_val("R8 irq low after status read", {31'd0, irq}, 32'd0);
    bus_write(4'h0, 32'h0003_0002);
    pulses(2);
    check_val("R8 irq on increment enable", {31'd0, irq}, 32'd1);
    bus_read(4'hC, 32'h2, "R6 no alarm past match");
    bus_write(4'h0, 32'h0002_0002);
    pulses(2);
    check_val("R8 increment enable only", {31'd0, irq}, 32'd1);
    bus_write(4'h0, 32'h0001_0002);
    check_val("R8 masked increment", {31'd0, irq}, 32'd0);

    // R6 all-ones disarms
    bus_write(4'h4, 32'hFFFF_FFFF);
    bus_write(4'h0, 32'h0005_0002);
    bus_read(4'hC, 32'h2, "R7 clear before disarm test");
    pulses(6);
    bus_read(4'hC, 32'h2, "R6 disarmed gives no alarm");

    // R7 tick in the same cycle as a status read
    bus_write(4'h0, 32'h0004_0002);
    bus_read(4'hC, 32'h0, "R7 clear before overlap");
    pulses(1);
    read_with_pulse(4'hC, 32'h0, "R7 read during tick returns old");
    bus_read(4'hC, 32'h2, "R7 overlapping event kept");
    bus_read(4'h8, 32'd1, "R2 count after overlap");

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule